// File: doc/BRIEF.md
# Indexed Clock Register Port Controller

This block sits between a byte-wide host bus and the 128-byte register file of a real-time clock. The host uses two addresses. A write to the even address selects a register. An access to the odd address reads or writes the selected byte. The block holds the four control and status registers itself and applies their side effects:

- entering and leaving the frozen set mode,
- holding and releasing the sub-second divider,
- the read-only status register and status bit,
- the update-in-progress warning window.

A time-counter block, not part of this design, receives the outputs. `update_strobe` tells it when a second has ended. `reload_time` tells it to reload its time base from the register file. Its own updates of the time fields come back through the `upd_*` port.

The divider counts `TICKS_PER_SEC` pulses of `osc_tick` per second. The bus is a plain strobe interface with no back-pressure. A write strobe is accepted in the cycle it is raised. A read strobe returns data on `host_rdata` one cycle later.

Top module: `clock_reg_port`

## Requirements
- R1: A write to address 0 stores `host_wdata[6:0]` as the index. A read of address 0 returns 0xFF. Read data appears on `host_rdata` in the cycle after the read strobe.
- R2: Any index outside 0x0A–0x0D is a storage byte that reads back the last value written to it.
- R3: Host writes to index 0x0C (status) and index 0x0D have no effect. Bit 7 of index 0x0A always reads as the update-in-progress state, whatever the host wrote.
- R4: After reset, index 0x0A reads 0x26, 0x0B reads 0x02, 0x0C reads 0x00 and 0x0D reads 0x80. Storage bytes and the index read 0.
- R5: `clk_run` is 1 exactly when bit 7 (set mode) of 0x0B is 0 and bits 6:4 of 0x0A are at most 2.
- R6: A write of 0x0B with bit 7 = 1 stores bit 4 (update interrupt enable) as 0. While set mode is on, `uip` stays 0, no `update_strobe` occurs, and `upd_we` writes are dropped.
- R7: Writing 0x0A bits 6:5 = 11 holds the divider at zero with `clk_run` 0. A later write with bits 6:4 ≤ 2 restarts it at half a second, so the first `update_strobe` comes after `TICKS_PER_SEC/2` ticks.
- R8: While running, `uip` is 1 during the last `UIP_TICKS` ticks of each second and 0 otherwise.
- R9: `update_strobe` pulses on the tick that ends a second. It sets bit 4 of 0x0C. If bit 4 of 0x0B is 1, it also sets bit 7 of 0x0C, and `irq` follows bit 7.
- R10: A read of 0x0C returns its value and clears it. A flag set in the same cycle as that read is kept.
- R11: A time-field write (indices 0,2,4,6,7,8,9) made in set mode only updates storage. Leaving set mode while the divider is running pulses `reload_time` for one cycle. A time-field write while running also pulses it.
- R12: While running, `upd_we` writes `upd_data` into a time-field index. A host storage write in the same cycle takes the port and the `upd_we` write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| osc_tick | input | 1 | One pulse per divider tick |
| upd_we | input | 1 | Time-counter write strobe |
| upd_idx | input | 7 | Time-counter target index |
| upd_data | input | 8 | Time-counter write data |
| clk_run | output | 1 | Clock counting allowed |
| uip | output | 1 | Update-in-progress window |
| update_strobe | output | 1 | End-of-second pulse |
| reload_time | output | 1 | Reload time base from storage |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a host read of the status register and the end-of-second tick. The bench lines the divider up to its last count, then raises the tick and the read strobe together. It expects the read to return the old flags and a second read to show the fresh update flag. The second pair is a host storage write and a time-counter write to the same time field in one cycle. The bench expects the host byte to be the one read back.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam logic [6:0] IDX_CTLA = 7'h0A;
  localparam logic [6:0] IDX_CTLB = 7'h0B;
  localparam logic [6:0] IDX_STAT = 7'h0C;
  localparam logic [6:0] IDX_VALID = 7'h0D;
  localparam logic [7:0] RST_CTLA = 8'h26;
  localparam logic [7:0] RST_CTLB = 8'h02;
  localparam logic [7:0] RST_STAT = 8'h00;
  localparam logic [7:0] RST_VALID = 8'h80;
  localparam int B_SETMODE = 7;
  localparam int B_UPD_IE = 4;
  localparam int S_IRQ = 7;
  localparam int S_UPD = 4;

  function automatic logic is_time_idx(input logic [6:0] i);
    return (i == 7'h00) || (i == 7'h02) || (i == 7'h04) || (i == 7'h06) ||
           (i == 7'h07) || (i == 7'h08) || (i == 7'h09);
  endfunction

  function automatic logic div_enabled(input logic [7:0] a);
    return a[6:4] <= 3'd2;
  endfunction

  function automatic logic div_held(input logic [7:0] a);
    return a[6:5] == 2'b11;
  endfunction
endpackage

// File: rtl/cpc_storage.sv
module cpc_storage #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cpc_divider.sv
module cpc_divider #(
  parameter int TICKS = 32768,
  parameter int UIP_TICKS = 8,
  localparam int SW = $clog2(TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic count_en,
  input  logic hold,
  input  logic load_half,
  input  logic run,
  output logic uip,
  output logic strobe
);
  localparam logic [SW-1:0] LAST = SW'(TICKS - 1);
  localparam logic [SW-1:0] WIN  = SW'(TICKS - UIP_TICKS);
  localparam logic [SW-1:0] HALF = SW'(TICKS / 2);

  logic [SW-1:0] sub;

  always_ff @(posedge clk) begin
    if (!rst_n)                    sub <= '0;
    else if (load_half)            sub <= HALF;
    else if (hold)                 sub <= '0;
    else if (count_en && osc_tick) sub <= (sub == LAST) ? '0 : sub + 1'b1;
  end

  assign strobe = osc_tick && count_en && run && (sub == LAST);
  assign uip    = run && (sub >= WIN);
endmodule

// File: rtl/clock_reg_port.sv
module clock_reg_port
  import cpc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_re,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       osc_tick,
  input  logic       upd_we,
  input  logic [6:0] upd_idx,
  input  logic [7:0] upd_data,
  output logic       clk_run,
  output logic       uip,
  output logic       update_strobe,
  output logic       reload_time,
  output logic       irq
);
  logic [6:0] idx;
  logic [7:0] reg_a, reg_b, reg_c, reg_d;
  logic [7:0] st_rdata, st_wdata, c_next, b_next;
  logic [6:0] st_waddr;
  logic       data_wr, is_ctrl, st_host, upd_ok, st_we;
  logic       a_wr, b_wr, c_rd, load_half, reload_d;

  assign data_wr = host_we && host_addr;
  assign clk_run = !reg_b[B_SETMODE] && div_enabled(reg_a);
  assign is_ctrl = (idx == IDX_CTLA) || (idx == IDX_CTLB) ||
                   (idx == IDX_STAT) || (idx == IDX_VALID);
  assign st_host = data_wr && !is_ctrl;
  assign upd_ok  = upd_we && clk_run && is_time_idx(upd_idx) && !st_host;
  assign st_we    = st_host || upd_ok;
  assign st_waddr = st_host ? idx : upd_idx;
  assign st_wdata = st_host ? host_wdata : upd_data;

  assign a_wr = data_wr && (idx == IDX_CTLA);
  assign b_wr = data_wr && (idx == IDX_CTLB);
  assign c_rd = host_re && host_addr && (idx == IDX_STAT);
  assign load_half = a_wr && div_held(reg_a) && div_enabled(host_wdata);

  cpc_storage #(.DEPTH(128), .WIDTH(8)) i_storage (
    .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr),
    .wdata(st_wdata), .raddr(idx), .rdata(st_rdata)
  );

  cpc_divider #(.TICKS(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) i_divider (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .count_en(div_enabled(reg_a)), .hold(div_held(reg_a)),
    .load_half(load_half), .run(clk_run), .uip(uip), .strobe(update_strobe)
  );

  always_comb begin
    b_next = host_wdata;
    if (host_wdata[B_SETMODE]) b_next[B_UPD_IE] = 1'b0;
  end

  always_comb begin
    c_next = c_rd ? 8'h00 : reg_c;
    if (update_strobe) begin
      c_next[S_UPD] = 1'b1;
      if (reg_b[B_UPD_IE]) c_next[S_IRQ] = 1'b1;
    end
  end

  assign reload_d = (b_wr && !host_wdata[B_SETMODE] && reg_b[B_SETMODE] &&
                     div_enabled(reg_a)) ||
                    (st_host && is_time_idx(idx) && clk_run);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx         <= '0;
      reg_a       <= RST_CTLA;
      reg_b       <= RST_CTLB;
      reg_c       <= RST_STAT;
      reg_d       <= RST_VALID;
      reload_time <= 1'b0;
      host_rdata  <= 8'h00;
    end else begin
      if (host_we && !host_addr) idx <= host_wdata[6:0];
      if (a_wr) reg_a <= {1'b0, host_wdata[6:0]};
      if (b_wr) reg_b <= b_next;
      reg_c       <= c_next;
      reload_time <= reload_d;
      if (host_re) begin
        if (!host_addr) host_rdata <= 8'hFF;
        else begin
          case (idx)
            IDX_CTLA:  host_rdata <= {uip, reg_a[6:0]};
            IDX_CTLB:  host_rdata <= reg_b;
            IDX_STAT:  host_rdata <= reg_c;
            IDX_VALID: host_rdata <= reg_d;
            default:   host_rdata <= st_rdata;
          endcase
        end
      end
    end
  end

  assign irq = reg_c[S_IRQ];
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       host_we,
  input logic       host_re,
  input logic       host_addr,
  input logic [6:0] idx,
  input logic [7:0] reg_a,
  input logic [7:0] reg_b,
  input logic [7:0] reg_c,
  input logic       update_strobe,
  input logic       uip,
  input logic       clk_run,
  input logic       irq
);
  // R3
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr && idx == 7'h0C && !host_re && !update_strobe)
      |=> (reg_c == $past(reg_c)));
  // R6
  set_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_b[7] |-> !reg_b[4]);
  // R8
  uip_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uip |-> clk_run);
  // R9
  strobe_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_strobe |=> reg_c[4]);
  // R7
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_a[6:5] == 2'b11) |-> (!update_strobe && !clk_run));
  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> reg_c[4]);
endmodule

bind clock_reg_port cpc_checker i_cpc_checker (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
  .host_addr(host_addr), .idx(idx), .reg_a(reg_a), .reg_b(reg_b),
  .reg_c(reg_c), .update_strobe(update_strobe), .uip(uip),
  .clk_run(clk_run), .irq(irq)
);

// File: tb/test_clock_reg_port.sv
module test_clock_reg_port;
  localparam int TICKS = 64;
  localparam int UIPW = 8;

  logic clk = 0, rst_n = 0;
  logic host_we = 0, host_re = 0, host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic osc_tick = 0, upd_we = 0;
  logic [6:0] upd_idx = 0;
  logic [7:0] upd_data = 0;
  logic clk_run, uip, update_strobe, reload_time, irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_mem [128];
  logic [7:0] d;

  always #4 clk = ~clk;

  clock_reg_port #(.TICKS_PER_SEC(TICKS), .UIP_TICKS(UIPW)) i_clock_reg_port (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .osc_tick(osc_tick), .upd_we(upd_we), .upd_idx(upd_idx),
    .upd_data(upd_data), .clk_run(clk_run), .uip(uip),
    .update_strobe(update_strobe), .reload_time(reload_time), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    host_we = 1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    host_re = 1; host_addr = a;
    @(negedge clk);
    host_re = 0;
    v = host_rdata;
  endtask

  task automatic rd_at(input logic [6:0] i, output logic [7:0] v);
    wr(0, {1'b0, i});
    rd(1, v);
  endtask

  task automatic tick(input int n);
    osc_tick = 1;
    repeat (n) @(negedge clk);
    osc_tick = 0;
  endtask

  function automatic logic [6:0] rand_general();
    return 7'(7'h0E + ($urandom % 114));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4 reset state
    rd(1, d); chk("R4 index0 byte", d, 8'h00);
    rd_at(7'h0A, d); chk("R4 reg A", d, 8'h26);
    rd_at(7'h0B, d); chk("R4 reg B", d, 8'h02);
    rd_at(7'h0C, d); chk("R4 reg C", d, 8'h00);
    rd_at(7'h0D, d); chk("R4 reg D", d, 8'h80);
    chk("R5 run after reset", {7'b0, clk_run}, 8'h01);
    // R1 index port
    rd(0, d); chk("R1 even read", d, 8'hFF);
    wr(0, 8'h8E); wr(1, 8'h5A); exp_mem[8'h0E] = 8'h5A;
    rd_at(7'h0E, d); chk("R1 index low bits", d, 8'h5A);

    // R2 random storage traffic
    for (int k = 0; k < 40; k++) begin
      logic [6:0] ri; logic [7:0] rv;
      ri = rand_general(); rv = 8'($urandom);
      wr(0, {1'b0, ri}); wr(1, rv); exp_mem[ri] = rv;
      if (k % 4 == 3) begin
        ri = rand_general();
        rd_at(ri, d); chk("R2 storage readback", d, exp_mem[ri]);
      end
    end
    for (int a = 1; a < 6; a += 2) begin
      wr(0, 8'(a)); wr(1, 8'(8'hC0 + a)); exp_mem[a] = 8'(8'hC0 + a);
      rd(1, d); chk("R2 alarm byte storage", d, 8'(8'hC0 + a));
    end

    // R3 read-only status
    wr(0, 8'h0C); wr(1, 8'hFF); rd(1, d); chk("R3 reg C write ignored", d, 8'h00);
    wr(0, 8'h0D); wr(1, 8'h00); rd(1, d); chk("R3 reg D write ignored", d, 8'h80);
    wr(0, 8'h0A); wr(1, 8'hA6); rd(1, d); chk("R3 A bit7 not writable", d, 8'h26);

    // R8 uip window (sub=0 now)
    tick(TICKS - UIPW - 1);
    chk("R8 uip before window", {7'b0, uip}, 8'h00);
    rd(1, d); chk("R8 A before window", d, 8'h26);
    tick(1);
    chk("R8 uip in window", {7'b0, uip}, 8'h01);
    rd(1, d); chk("R8 A bit7 in window", d, 8'hA6);
    tick(UIPW - 1);

    // R10 read of C coinciding with end-of-second
    wr(0, 8'h0C);
    osc_tick = 1; host_re = 1; host_addr = 1;
    #1 chk("R9 strobe on last tick", {7'b0, update_strobe}, 8'h01);
    @(negedge clk);
    osc_tick = 0; host_re = 0;
    chk("R10 read returns old flags", host_rdata, 8'h00);
    chk("R8 uip after wrap", {7'b0, uip}, 8'h00);
    rd(1, d); chk("R10 flag kept across read", d, 8'h10);
    rd(1, d); chk("R10 read clears", d, 8'h00);

    // R9 interrupt with enable
    wr(0, 8'h0B); wr(1, 8'h12);
    tick(TICKS);
    chk("R9 irq raised", {7'b0, irq}, 8'h01);
    rd_at(7'h0C, d); chk("R9 C with irq", d, 8'h90);
    chk("R10 irq cleared by read", {7'b0, irq}, 8'h00);

    // R6 set mode
    wr(0, 8'h0B); wr(1, 8'h92);
    rd(1, d); chk("R6 UIE forced off", d, 8'h82);
    chk("R5 no run in set mode", {7'b0, clk_run}, 8'h00);
    tick(TICKS - 4);
    chk("R6 uip off in set mode", {7'b0, uip}, 8'h00);
    tick(10);
    rd_at(7'h0C, d); chk("R6 no update in set mode", d, 8'h00);
    upd_we = 1; upd_idx = 7'h00; upd_data = 8'h33;
    @(negedge clk); upd_we = 0;
    rd_at(7'h00, d); chk("R6 counter write dropped", d, 8'h00);
    wr(0, 8'h02); wr(1, 8'h45);
    chk("R11 no reload in set mode", {7'b0, reload_time}, 8'h00);
    rd(1, d); chk("R11 set-mode write stored", d, 8'h45);
    wr(0, 8'h0B); wr(1, 8'h02);
    chk("R11 reload on leaving set", {7'b0, reload_time}, 8'h01);
    @(negedge clk);
    chk("R11 reload one cycle", {7'b0, reload_time}, 8'h00);

    // R12 counter writes while running
    upd_we = 1; upd_idx = 7'h00; upd_data = 8'h59;
    @(negedge clk); upd_we = 0;
    rd_at(7'h00, d); chk("R12 counter write", d, 8'h59);
    wr(0, 8'h04);
    upd_we = 1; upd_idx = 7'h04; upd_data = 8'h22;
    wr(1, 8'h11);
    upd_we = 0;
    chk("R11 reload on running time write", {7'b0, reload_time}, 8'h01);
    rd(1, d); chk("R12 host wins conflict", d, 8'h11);

    // R5 / R7 divider hold and release
    wr(0, 8'h0A); wr(1, 8'h46);
    chk("R5 stopped divider", {7'b0, clk_run}, 8'h00);
    wr(1, 8'h66);
    chk("R7 hold stops run", {7'b0, clk_run}, 8'h00);
    tick(TICKS + 5);
    rd(1, d); chk("R7 A in hold", d, 8'h66);
    rd_at(7'h0C, d); chk("R7 no update in hold", d, 8'h00);
    wr(0, 8'h0A); wr(1, 8'h26);
    tick(TICKS / 2 - 1);
    rd_at(7'h0C, d); chk("R7 not before half second", d, 8'h00);
    tick(1);
    rd(1, d); chk("R7 first update at half second", d, 8'h10);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule